// File: doc/BRIEF.md
# Multi-Source Reset Timeout Generator

This block merges five fault sources into one system reset and holds that reset for a selectable stretch of time after the last fault has gone. The fault sources are three digital undervoltage flags (primary supply, secondary supply and an auxiliary monitor), an active-low manual-reset pin and a watchdog-expiry request. The manual-reset pin comes from outside the clock domain. It is synchronised and then filtered against short glitches.

The stretch is counted in pulses of a timebase tick input, not in clock cycles. A 3-bit code picks one of eight terminal counts, which are held in a parameter table. The defaults assume a 50 µs tick and give typical periods of 1.65, 13.2, 26.25, 52.5, 210, 420, 840 and 1680 ms for codes 0 to 7.

The block has three reset outputs:
- a main active-low reset;
- an optional active-high copy of the main reset;
- a second-domain active-low reset, which answers only to the two supply flags and the manual reset.

A one-cycle strobe marks each new entry into main reset.

Top module: `rst_timeout_gen`

## Requirements
- R1: The main reset `rst_no` goes low on the clock edge after any cause is active. The causes are: `pri_low_i`, `sec_low_i` or `aux_low_i` high, the filtered manual reset low, or `wdog_exp_i` high.
- R2: Once every cause is clear, `rst_no` stays low until TMO_TC[code] ticks have been counted. Only ticks sampled while no cause is active are counted. `rst_no` rises on the edge that samples the last of those ticks. With a tick on every cycle, a one-cycle cause keeps `rst_no` low for exactly TMO_TC[code] cycles.
- R3: A cause that becomes active again during the stretch restarts the count from zero.
- R4: The manual reset holds the reset for as long as its filtered value is low. The stretch begins only when the filtered value goes high again.
- R5: `tmo_sel_i` (values 0 to 7) selects entry TMO_TC[tmo_sel_i] of the terminal-count table.
- R6: `rst2_no` follows the same timing rules as `rst_no`, but only `pri_low_i`, `sec_low_i` and the manual reset are causes for it. A pulse on `aux_low_i` or `wdog_exp_i` leaves `rst2_no` high.
- R7: A one-cycle `wdog_exp_i` pulse produces one main reset pulse that lasts exactly the timeout.
- R8: The manual-reset path has a two-flop synchroniser followed by a filter of GLITCH_CYC cycles. The filtered value changes only after GLITCH_CYC consecutive synchronised samples disagree with it.
  - A low pulse shorter than GLITCH_CYC cycles has no effect on the outputs.
  - A low pulse of h ≥ GLITCH_CYC cycles, driven with a tick on every cycle, holds `rst_no` low for h + TMO_TC − 1 cycles when GLITCH_CYC is 4.
- R9: When HAS_RST_HI is 1, `rst_o` is always the inverse of `rst_no`. When HAS_RST_HI is 0, `rst_o` is tied to 0.
- R10: While `rst_ni` is low, `rst_no` and `rst2_no` are 0, `rst_o` is 1, `reset_event_o` is 0 and the count is zero. After release, both resets run one full timeout.
- R11: `reset_event_o` pulses high for one cycle, together with the first low cycle of `rst_no`. It stays low when a new cause arrives while `rst_no` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| tick_i | input | 1 | Timebase tick, one cycle wide per unit |
| pri_low_i | input | 1 | Primary supply below threshold |
| sec_low_i | input | 1 | Secondary supply below threshold |
| aux_low_i | input | 1 | Auxiliary monitor below threshold |
| mr_ni | input | 1 | Manual reset, active low, asynchronous |
| wdog_exp_i | input | 1 | Watchdog expiry request |
| tmo_sel_i | input | 3 | Timeout code |
| rst_no | output | 1 | Main reset, active low |
| rst_o | output | 1 | Main reset, active high (optional) |
| rst2_no | output | 1 | Second-domain reset, active low |
| reset_event_o | output | 1 | Strobe on each new entry into main reset |

## Verification
The assertions take these things about the inputs for granted:
- `tick_i` is a single-cycle pulse;
- the flags and `wdog_exp_i` are synchronous to `clk_i`;
- `tmo_sel_i` changes only while no timeout is running;
- every table entry is at least 1.

The stimulus drives every input on the falling edge. It changes the code only after both resets have released. It runs the tick either on every cycle or on every third cycle. Manual-reset pulses are chosen both just below and at or above the filter length.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int CODE_W    = 3;
  localparam int NUM_CODES = 1 << CODE_W;
  localparam int NUM_DOM   = 2;

  typedef enum int unsigned {
    DOM_MAIN = 0,
    DOM_SEC  = 1
  } dom_e;

  typedef struct packed {
    logic pri;
    logic sec;
    logic aux;
    logic mr;
    logic wdog;
  } cause_t;
endpackage

// File: rtl/mr_filter.sv
module mr_filter #(
  parameter int GLITCH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mr_ni,
  output logic mr_low_o
);
  localparam int GW = (GLITCH_CYC < 2) ? 1 : $clog2(GLITCH_CYC + 1);

  logic          s1_q, s2_q, filt_q;
  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      s1_q <= mr_ni;
      s2_q <= s1_q;
      if (s2_q != filt_q) begin
        if (cnt_q == GW'(GLITCH_CYC - 1)) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign mr_low_o = ~filt_q;

  // R8
  filt_follows_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(filt_q) |-> ($past(s2_q) == filt_q));
endmodule

// File: rtl/tmo_counter.sv
module tmo_counter
  import rtg_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [NUM_CODES-1:0][CNT_W-1:0] TMO_TC = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cause_i,
  input  logic              tick_i,
  input  logic [CODE_W-1:0] sel_i,
  output logic              active_o
);
  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tc;

  assign tc = TMO_TC[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (cause_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
    end else if (active_q && tick_i) begin
      // >= tolerates a code change mid-count
      if (cnt_q >= tc - CNT_W'(1)) begin
        active_q <= 1'b0;
        cnt_q    <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign active_o = active_q;

  // R1
  cause_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cause_i |=> active_q);

  // R2
  release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_q) |-> ($past(tick_i) && !$past(cause_i)));

  // R3
  hold_under_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && cause_i) |=> active_q);
endmodule

// File: rtl/rst_timeout_gen.sv
module rst_timeout_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter logic [NUM_CODES-1:0][CNT_W-1:0] TMO_TC = {
    16'd33600, 16'd16800, 16'd8400, 16'd4200,
    16'd1050,  16'd525,   16'd264,  16'd33},
  parameter int GLITCH_CYC = 4,
  parameter bit HAS_RST_HI = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pri_low_i,
  input  logic              sec_low_i,
  input  logic              aux_low_i,
  input  logic              mr_ni,
  input  logic              wdog_exp_i,
  input  logic [CODE_W-1:0] tmo_sel_i,
  output logic              rst_no,
  output logic              rst_o,
  output logic              rst2_no,
  output logic              reset_event_o
);
  cause_t             cz;
  logic               mr_low;
  logic [NUM_DOM-1:0] dom_cause, dom_act;
  logic               event_q;

  mr_filter #(.GLITCH_CYC(GLITCH_CYC)) u_mr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mr_ni    (mr_ni),
    .mr_low_o (mr_low)
  );

  assign cz = '{pri: pri_low_i, sec: sec_low_i, aux: aux_low_i,
                mr: mr_low, wdog: wdog_exp_i};

  assign dom_cause[DOM_MAIN] = |cz;
  assign dom_cause[DOM_SEC]  = cz.pri | cz.sec | cz.mr;

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    tmo_counter #(.CNT_W(CNT_W), .TMO_TC(TMO_TC)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cause_i  (dom_cause[d]),
      .tick_i   (tick_i),
      .sel_i    (tmo_sel_i),
      .active_o (dom_act[d])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) event_q <= 1'b0;
    else         event_q <= dom_cause[DOM_MAIN] & ~dom_act[DOM_MAIN];
  end

  assign rst_no        = ~dom_act[DOM_MAIN];
  assign rst2_no       = ~dom_act[DOM_SEC];
  assign reset_event_o = event_q;

  if (HAS_RST_HI) begin : g_hi
    assign rst_o = dom_act[DOM_MAIN];
  end else begin : g_no_hi
    assign rst_o = 1'b0;
  end

  // R6
  sec_within_main_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dom_act[DOM_MAIN] |-> !dom_act[DOM_SEC]);

  // R11
  event_marks_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    event_q |-> (dom_act[DOM_MAIN] && !$past(dom_act[DOM_MAIN])));
endmodule

// File: tb/rst_timeout_gen_test.sv
`timescale 1ns/1ps
module rst_timeout_gen_test;
  localparam int G = 4;
  localparam int TCB [8] = '{1, 2, 4, 6, 9, 13, 17, 20};

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic pri = 1'b0, sec = 1'b0, aux = 1'b0, mr_n = 1'b1, wdog = 1'b0;
  logic [2:0] sel = 3'd3;
  logic rst_no, rst_o, rst2_no, ev;

  int checks = 0, fails = 0, cyc = 0, tick_div = 1, tick_cnt = 0;

  always #10 clk = ~clk;

  rst_timeout_gen #(
    .CNT_W(8),
    .TMO_TC({8'd20, 8'd17, 8'd13, 8'd9, 8'd6, 8'd4, 8'd2, 8'd1}),
    .GLITCH_CYC(G),
    .HAS_RST_HI(1'b1)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .pri_low_i(pri), .sec_low_i(sec),
    .aux_low_i(aux), .mr_ni(mr_n), .wdog_exp_i(wdog), .tmo_sel_i(sel),
    .rst_no(rst_no), .rst_o(rst_o), .rst2_no(rst2_no), .reset_event_o(ev)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  int  m_el [2];
  bit  m_act [2];
  bit  m_ev, m_filt;
  bit  hist [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act[0] = 1; m_act[1] = 1; m_el[0] = 0; m_el[1] = 0;
      m_ev = 0; m_filt = 1;
      hist.delete();
      for (int i = 0; i < G + 2; i++) hist.push_back(1'b1);
    end else begin
      bit c [2];
      bit all_diff;
      c[0] = pri | sec | aux | !m_filt | wdog;
      c[1] = pri | sec | !m_filt;
      m_ev = c[0] && !m_act[0];
      for (int d = 0; d < 2; d++) begin
        if (c[d]) begin
          m_act[d] = 1; m_el[d] = 0;
        end else if (m_act[d] && tick) begin
          m_el[d] = m_el[d] + 1;
          if (m_el[d] >= TCB[sel]) begin
            m_act[d] = 0; m_el[d] = 0;
          end
        end
      end
      hist.push_back(mr_n);
      void'(hist.pop_front());
      all_diff = 1;
      for (int i = 0; i < G; i++) if (hist[i] == m_filt) all_diff = 0;
      if (all_diff) m_filt = !m_filt;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(rst_no == !m_act[0], "R1/R2/R3 rst_no vs model", rst_no, !m_act[0]);
      chk(rst2_no == !m_act[1], "R6 rst2_no vs model", rst2_no, !m_act[1]);
      chk(rst_o == !rst_no, "R9 rst_o inverse", rst_o, !rst_no);
      chk(ev == m_ev, "R11 reset_event vs model", ev, m_ev);
    end
    tick_cnt++;
    if (tick_cnt >= tick_div) begin tick = 1'b1; tick_cnt = 0; end
    else tick = 1'b0;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic wait_idle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rst_no && rst2_no) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic set_src(input int which, input logic v);
    case (which)
      0: pri = v;
      1: sec = v;
      2: aux = v;
      3: wdog = v;
      default: mr_n = !v;
    endcase
  endtask

  // which: 0 pri, 1 sec, 2 aux, 3 wdog, 4 mr
  task automatic pulse(input int which, input int hold,
                       output int lo, output int lo2, output int evs);
    lo = 0; lo2 = 0; evs = 0;
    @(negedge clk); set_src(which, 1'b1);
    for (int i = 1; i < hold + 80; i++) begin
      @(negedge clk);
      if (i == hold) set_src(which, 1'b0);
      if (!rst_no) lo++;
      if (!rst2_no) lo2++;
      if (ev) evs++;
    end
  endtask

  int lo, lo2, evs;

  initial begin
    repeat (3) @(negedge clk);
    chk(rst_no == 0 && rst2_no == 0, "R10 reset state resets", {rst_no, rst2_no}, 0);
    chk(rst_o == 1 && ev == 0, "R10 reset state rst_o/event", {rst_o, ev}, 2);
    rst_n = 1'b1;
    lo = 0;
    for (int i = 0; i < 60; i++) begin
      if (!rst_no) lo++;
      @(negedge clk);
    end
    chk(lo == TCB[3], "R10 power-on stretch", lo, TCB[3]);

    sel = 3'd2; wait_idle();
    pulse(0, 1, lo, lo2, evs);
    chk(lo == TCB[2], "R2 primary 1-cycle stretch", lo, TCB[2]);
    chk(evs == 1, "R11 one strobe", evs, 1);
    wait_idle();
    pulse(0, 5, lo, lo2, evs);
    chk(lo == 4 + TCB[2], "R2 primary held 5", lo, 4 + TCB[2]);
    wait_idle();
    pulse(1, 1, lo, lo2, evs);
    chk(lo2 == TCB[2], "R6 secondary follows sec flag", lo2, TCB[2]);
    wait_idle();
    pulse(2, 1, lo, lo2, evs);
    chk(lo == TCB[2], "R1 aux asserts main", lo, TCB[2]);
    chk(lo2 == 0, "R6 aux ignored by secondary", lo2, 0);
    wait_idle();
    pulse(3, 1, lo, lo2, evs);
    chk(lo == TCB[2], "R7 watchdog pulse exact", lo, TCB[2]);
    chk(lo2 == 0, "R6 watchdog ignored by secondary", lo2, 0);

    // R3 restart
    sel = 3'd5; wait_idle();
    lo = 0;
    @(negedge clk); pri = 1'b1;
    @(negedge clk); pri = 1'b0; if (!rst_no) lo++;
    @(negedge clk); if (!rst_no) lo++;
    @(negedge clk); if (!rst_no) lo++; aux = 1'b1;
    @(negedge clk); aux = 1'b0;
    for (int i = 0; i < 60; i++) begin
      if (!rst_no) lo++;
      @(negedge clk);
    end
    chk(lo == 3 + TCB[5], "R3 restart on re-assert", lo, 3 + TCB[5]);

    // R11 no strobe while already in reset
    wait_idle();
    evs = 0;
    @(negedge clk); pri = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i == 2) wdog = 1'b1;
      if (i == 3) wdog = 1'b0;
      if (ev) evs++;
    end
    pri = 1'b0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (ev) evs++; end
    chk(evs == 1, "R11 no strobe when already asserted", evs, 1);

    // R8 glitch filter
    sel = 3'd3; wait_idle();
    pulse(4, G - 1, lo, lo2, evs);
    chk(lo == 0 && lo2 == 0, "R8 short manual pulse ignored", lo + lo2, 0);
    wait_idle();
    pulse(4, G, lo, lo2, evs);
    chk(lo == G + TCB[3] - 1, "R8 manual pulse honoured", lo, G + TCB[3] - 1);
    chk(lo2 == G + TCB[3] - 1, "R6 manual on secondary", lo2, G + TCB[3] - 1);
    wait_idle();
    pulse(4, 10, lo, lo2, evs);
    chk(lo == 10 + TCB[3] - 1, "R4 manual held then stretch", lo, 10 + TCB[3] - 1);

    // R5 every code
    for (int k = 0; k < 8; k++) begin
      sel = 3'(k); wait_idle();
      pulse(3, 1, lo, lo2, evs);
      chk(lo == TCB[k], $sformatf("R5 code %0d", k), lo, TCB[k]);
    end

    // slow tick, model-compared
    tick_div = 3; sel = 3'd4; wait_idle();
    pulse(0, 2, lo, lo2, evs);
    pulse(4, 7, lo, lo2, evs);
    pulse(3, 1, lo, lo2, evs);
    chk(lo > TCB[4], "R2 slow tick lengthens stretch", lo, TCB[4]);

    wait_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule